// File: doc/BRIEF.md
# Latched Pulse Accumulator Pair

This block holds two event counters, a low one and a high one, each advanced by a one-cycle event strobe coming from already filtered pin logic. Each counter has a snapshot register beside it; a single latch strobe, raised by the periodic time base or by software, copies both live counts into their snapshot registers on the same edge. This freezes a consistent pair of values that can be read later, while counting goes on.

A small mode machine selects how the pair behaves. In split mode the counters are independent 8-bit accumulators that stop at their top value and raise a sticky overflow flag. In chained mode the pair forms one 16-bit accumulator driven only by the low strobe: the high counter advances on the low counter's rollover, and the high strobe is ignored. The machine has three states: OFF (counting stopped), SPLIT and CHAIN. It takes the transition to OFF whenever the enable is low, to SPLIT when the enable is high and the cascade select low, and to CHAIN when both are high. Any state can reach any other state in one cycle.

Top module: `pacc_pair`

## Requirements
- R1: While reset is asserted, and right after it is released, both live counts, both held counts and both overflow flags read zero and the mode machine is in OFF.
- R2: In SPLIT, each event strobe high at a clock edge adds one to its own counter at that edge, independently of the other counter.
- R3: In SPLIT, a counter at 0xFF that receives an event stays at 0xFF and its overflow flag becomes 1; the flag stays 1 until a read or clear strobe for that counter.
- R4: In CHAIN, the value {cnt_hi, cnt_lo} advances by one per low event strobe; the high counter advances only on the low counter's rollover from 0xFF to 0x00, and evt_hi has no effect on any output.
- R5: In CHAIN, an event at {cnt_hi, cnt_lo} = 0xFFFF wraps the pair to 0x0000 and sets ovf_hi; ovf_lo is not set by the low counter's rollover.
- R6: The mode machine samples en and cascade at each edge, so a new mode governs events from the following edge on; an event at the same edge as a mode change is handled by the previous mode.
- R7: In OFF, event strobes change no live count and set no flag.
- R8: A latch strobe at an edge loads hold_lo and hold_hi with the live counts as they were before that edge; without a latch strobe, the held counts do not change.
- R9: A clear strobe empties its live counter and overflow flag at that edge, taking priority over an event at the same edge; a held count is unaffected.
- R10: A read strobe clears the overflow flag of its counter and changes no live or held count; an overflow event at the same edge wins and leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Counting enable |
| cascade | input | 1 | 1 selects chained 16-bit mode, 0 split mode |
| evt_lo | input | 1 | One-cycle event strobe for the low counter |
| evt_hi | input | 1 | One-cycle event strobe for the high counter |
| latch | input | 1 | Snapshot strobe for both holding registers |
| clr_lo | input | 1 | Clear strobe for the low counter and its flag |
| clr_hi | input | 1 | Clear strobe for the high counter and its flag |
| rd_lo | input | 1 | Read strobe for the low counter; clears its flag |
| rd_hi | input | 1 | Read strobe for the high counter; clears its flag |
| cnt_lo | output | 8 | Live low count |
| cnt_hi | output | 8 | Live high count |
| hold_lo | output | 8 | Held low count |
| hold_hi | output | 8 | Held high count |
| ovf_lo | output | 1 | Sticky overflow flag of the low counter |
| ovf_hi | output | 1 | Sticky overflow flag of the high counter (16-bit wrap in CHAIN) |

## Verification
Counts, flags and held values all change at the edge that samples the strobes. They can be read one edge later, with no extra pipeline stage. A change of en or cascade only takes effect for events one edge after the edge that samples it, because the mode state sits in a register. The bench drives every input on the falling edge and updates its reference model at each rising edge, using the mode the model held before that edge. It compares all outputs on the next falling edge, so each check sees the result of exactly one edge. The chained wrap is reached by counting through all 65536 values.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SPLIT = 2'd1,
        ST_CHAIN = 2'd2
    } pacc_mode_e;

endpackage

// File: rtl/pacc_mode_fsm.sv
module pacc_mode_fsm
    import pacc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cascade,
    output pacc_mode_e state,
    output logic       count_on,
    output logic       chained
);

    pacc_mode_e state_nxt;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (en) state_nxt = cascade ? ST_CHAIN : ST_SPLIT;
            end
            ST_SPLIT: begin
                if (!en)         state_nxt = ST_OFF;
                else if (cascade) state_nxt = ST_CHAIN;
            end
            ST_CHAIN: begin
                if (!en)          state_nxt = ST_OFF;
                else if (!cascade) state_nxt = ST_SPLIT;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // outputs
    always_comb begin
        count_on = 1'b0;
        chained  = 1'b0;
        unique case (state)
            ST_OFF:   begin count_on = 1'b0; chained = 1'b0; end
            ST_SPLIT: begin count_on = 1'b1; chained = 1'b0; end
            ST_CHAIN: begin count_on = 1'b1; chained = 1'b1; end
            default:  begin count_on = 1'b0; chained = 1'b0; end
        endcase
    end

    // R6: the registered mode follows en/cascade one edge later
    a_r6_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state == ($past(en) ? ($past(cascade) ? ST_CHAIN : ST_SPLIT) : ST_OFF)));

    // R1: a legal state only
    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3);

endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wrap,
    input  logic         flag_top,
    input  logic         clr,
    input  logic         rd,
    output logic [W-1:0] cnt,
    output logic         carry,
    output logic         ovf
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic at_top;
    logic set_ovf;

    assign at_top  = (cnt == TOP);
    assign carry   = inc & at_top & wrap & ~clr;
    assign set_ovf = inc & at_top & flag_top & ~clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            if (!at_top)   cnt <= cnt + 1'b1;
            else if (wrap) cnt <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (clr)     ovf <= 1'b0;
        else if (set_ovf) ovf <= 1'b1;
        else if (rd)      ovf <= 1'b0;
    end

    // R3: saturating counter holds its top value
    a_r3_sat_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top && inc && !wrap && !clr) |=> (cnt == TOP));

    // R3: flag set when saturating with flagging enabled
    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top && inc && flag_top && !clr) |=> ovf);

    // R9: clear empties the counter and flag
    a_r9_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !ovf));

    // R7: no increment request, no movement
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt));

    // R10: read without a new overflow drops the flag
    a_r10_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !clr && !(inc && at_top && flag_top)) |=> !ovf);

endmodule

// File: rtl/pacc_hold.sv
module pacc_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch,
    input  logic [W-1:0] live,
    output logic [W-1:0] held
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     held <= '0;
        else if (latch) held <= live;
    end

    // R8: a latch copies the pre-edge live value
    a_r8_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (held == $past(live)));

    // R8: without a latch the held value stays
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(held));

endmodule

// File: rtl/pacc_pair.sv
module pacc_pair
    import pacc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cascade,
    input  logic         evt_lo,
    input  logic         evt_hi,
    input  logic         latch,
    input  logic         clr_lo,
    input  logic         clr_hi,
    input  logic         rd_lo,
    input  logic         rd_hi,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi,
    output logic [W-1:0] hold_lo,
    output logic [W-1:0] hold_hi,
    output logic         ovf_lo,
    output logic         ovf_hi
);

    localparam int NCH = 2;

    pacc_mode_e mode;
    logic       count_on;
    logic       chained;

    logic [NCH-1:0]        inc_v;
    logic [NCH-1:0]        wrap_v;
    logic [NCH-1:0]        flag_v;
    logic [NCH-1:0]        clr_v;
    logic [NCH-1:0]        rd_v;
    logic [NCH-1:0]        carry_v;
    logic [NCH-1:0]        ovf_v;
    logic [NCH-1:0][W-1:0] cnt_v;
    logic [NCH-1:0][W-1:0] held_v;

    pacc_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cascade  (cascade),
        .state    (mode),
        .count_on (count_on),
        .chained  (chained)
    );

    // steering: index 0 is the low counter, index 1 the high counter
    always_comb begin
        inc_v[0]  = count_on & evt_lo;
        inc_v[1]  = count_on & (chained ? carry_v[0] : evt_hi);
        wrap_v[0] = chained;
        wrap_v[1] = chained;
        flag_v[0] = ~chained;
        flag_v[1] = 1'b1;
        clr_v     = {clr_hi, clr_lo};
        rd_v      = {rd_hi, rd_lo};
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pacc_counter #(.W(W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (inc_v[g]),
            .wrap     (wrap_v[g]),
            .flag_top (flag_v[g]),
            .clr      (clr_v[g]),
            .rd       (rd_v[g]),
            .cnt      (cnt_v[g]),
            .carry    (carry_v[g]),
            .ovf      (ovf_v[g])
        );
        pacc_hold #(.W(W)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .latch (latch),
            .live  (cnt_v[g]),
            .held  (held_v[g])
        );
    end

    assign cnt_lo  = cnt_v[0];
    assign cnt_hi  = cnt_v[1];
    assign hold_lo = held_v[0];
    assign hold_hi = held_v[1];
    assign ovf_lo  = ovf_v[0];
    assign ovf_hi  = ovf_v[1];

    // R4: in chain mode the high byte moves only on a low rollover
    a_r4_hi_by_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_CHAIN && !clr_hi && !(evt_lo && !clr_lo && cnt_lo == {W{1'b1}}))
        |=> $stable(cnt_hi));

    // R5: chain rollover of the low byte never raises ovf_lo
    a_r5_no_lo_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_CHAIN && !ovf_lo) |=> !ovf_lo);

    // R7: stopped counters keep their values
    a_r7_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_OFF && !clr_lo && !clr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

endmodule

// File: tb/pacc_pair_test.sv
module pacc_pair_test;

    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 8;
    localparam int  WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n;
    logic en, cascade, evt_lo, evt_hi, latch, clr_lo, clr_hi, rd_lo, rd_hi;
    logic [W-1:0] cnt_lo, cnt_hi, hold_lo, hold_hi;
    logic ovf_lo, ovf_hi;

    int compared   = 0;
    int mismatched = 0;
    int cycles     = 0;
    bit done       = 0;

    // reference state: mode 0 off, 1 split, 2 chain
    int       m_mode;
    logic [7:0] m_lo, m_hi, m_hlo, m_hhi;
    logic     m_olo, m_ohi;

    always #(CLK_PERIOD/2) clk = ~clk;

    pacc_pair #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .cascade(cascade),
        .evt_lo(evt_lo), .evt_hi(evt_hi), .latch(latch),
        .clr_lo(clr_lo), .clr_hi(clr_hi), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .hold_lo(hold_lo), .hold_hi(hold_hi),
        .ovf_lo(ovf_lo), .ovf_hi(ovf_hi)
    );

    function automatic int next_mode(input logic e, input logic c);
        return e ? (c ? 2 : 1) : 0;
    endfunction

    task automatic model_reset();
        m_mode = 0; m_lo = 0; m_hi = 0; m_hlo = 0; m_hhi = 0; m_olo = 0; m_ohi = 0;
    endtask

    // one edge of the reference model, computed from the requirements
    task automatic model_edge();
        logic [7:0] lo_n, hi_n;
        logic       olo_n, ohi_n, inc_lo, inc_hi, carry, set_lo, set_hi;
        lo_n = m_lo; hi_n = m_hi; olo_n = m_olo; ohi_n = m_ohi;
        inc_lo = (m_mode != 0) && evt_lo;
        carry  = (m_mode == 2) && inc_lo && !clr_lo && (m_lo == 8'hFF);
        inc_hi = (m_mode == 1) ? evt_hi : carry;
        set_lo = (m_mode == 1) && inc_lo && (m_lo == 8'hFF) && !clr_lo;
        set_hi = (m_mode != 0) && inc_hi && (m_hi == 8'hFF) && !clr_hi;
        if (clr_lo) lo_n = 0;
        else if (inc_lo) lo_n = (m_lo != 8'hFF) ? m_lo + 1 : ((m_mode == 2) ? 8'h00 : 8'hFF);
        if (clr_hi) hi_n = 0;
        else if (inc_hi) hi_n = (m_hi != 8'hFF) ? m_hi + 1 : ((m_mode == 2) ? 8'h00 : 8'hFF);
        if (clr_lo) olo_n = 0; else if (set_lo) olo_n = 1; else if (rd_lo) olo_n = 0;
        if (clr_hi) ohi_n = 0; else if (set_hi) ohi_n = 1; else if (rd_hi) ohi_n = 0;
        if (latch) begin m_hlo = m_lo; m_hhi = m_hi; end
        m_lo = lo_n; m_hi = hi_n; m_olo = olo_n; m_ohi = ohi_n;
        m_mode = next_mode(en, cascade);
    endtask

    task automatic check(input string tag);
        compared++;
        if (cnt_lo !== m_lo || cnt_hi !== m_hi || hold_lo !== m_hlo ||
            hold_hi !== m_hhi || ovf_lo !== m_olo || ovf_hi !== m_ohi) begin
            mismatched++;
            $display("FAIL %s: got cnt=%h/%h hold=%h/%h ovf=%b/%b exp cnt=%h/%h hold=%h/%h ovf=%b/%b",
                     tag, cnt_hi, cnt_lo, hold_hi, hold_lo, ovf_hi, ovf_lo,
                     m_hi, m_lo, m_hhi, m_hlo, m_ohi, m_olo);
        end
    endtask

    task automatic quiet();
        evt_lo = 0; evt_hi = 0; latch = 0; clr_lo = 0; clr_hi = 0; rd_lo = 0; rd_hi = 0;
    endtask

    // inputs are set at a falling edge; this advances one rising edge and checks
    task automatic step(input string tag, input bit do_check = 1);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (do_check) check(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                mismatched++;
                $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst_n = 0; en = 0; cascade = 0; quiet();
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1;
        step("R1 after reset");

        // R6: enable and an event at the same edge; event handled by OFF
        en = 1; evt_lo = 1; evt_hi = 1;
        step("R6 event at mode change");
        step("R2 first split events");
        quiet();

        // R2: independent counting with mixed patterns
        for (int i = 0; i < 40; i++) begin
            evt_lo = i[0]; evt_hi = (i % 3 == 0);
            step("R2 split counting");
        end
        quiet();

        // R8: latch then move on, held stays
        latch = 1; step("R8 latch");
        latch = 0; evt_lo = 1; evt_hi = 1;
        for (int i = 0; i < 5; i++) step("R8 held stable");

        // R3: saturate the low counter
        evt_hi = 0;
        for (int i = 0; i < 260; i++) step("R3 saturation");
        quiet();
        // R10: read clears flag, counts and holds unchanged
        rd_lo = 1; step("R10 read clears flag");
        rd_lo = 0;
        evt_lo = 1; step("R3 saturate again");
        evt_lo = 1; rd_lo = 1; step("R10 set beats read");
        quiet();
        // R9: clear beats event, hold untouched
        latch = 1; step("R8 latch at top");
        latch = 0; clr_lo = 1; evt_lo = 1; step("R9 clear wins");
        quiet();

        // R7: disabled, events ignored
        en = 0; step("R7 disable");
        evt_lo = 1; evt_hi = 1;
        for (int i = 0; i < 10; i++) step("R7 off ignores events");
        quiet();

        // R4/R5: chained mode full 16-bit wrap
        en = 1; cascade = 1; clr_lo = 1; clr_hi = 1; step("R9 clear both");
        quiet();
        evt_lo = 1; evt_hi = 1;
        for (int i = 0; i < 65535; i++) step("R4 chain count", (i % 251 == 0) || (i > 65530));
        check("R4 chain at 0xFFFF");
        step("R5 chain wrap");
        evt_hi = 0; evt_lo = 0;
        step("R5 after wrap");
        evt_hi = 1;
        for (int i = 0; i < 4; i++) step("R4 high pin ignored");
        quiet();
        rd_hi = 1; step("R10 read high flag");
        quiet();

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 3) en = ~en;
            if ($urandom_range(0, 99) < 3) cascade = ~cascade;
            evt_lo = ($urandom_range(0, 99) < 70);
            evt_hi = ($urandom_range(0, 99) < 60);
            latch  = ($urandom_range(0, 99) < 10);
            clr_lo = ($urandom_range(0, 99) < 2);
            clr_hi = ($urandom_range(0, 99) < 2);
            rd_lo  = ($urandom_range(0, 99) < 5);
            rd_hi  = ($urandom_range(0, 99) < 5);
            step("RND mix");
        end
        quiet();
        step("RND final");
        finish_run();
    end

endmodule